// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs one 8-bit successive-approximation conversion at a time. It drives a track/hold control and a trial code into an external comparator and capacitor array, and reads back one comparator decision per trial. Bits are resolved most significant first. Each bit gets a fixed number of ticks of the local oscillator clock. The comparator decision is sampled on the last tick of that bit. The finished code is presented in straight binary together with a valid flag.

A conversion is launched by a single-cycle start pulse from the serial front end. The front end has already brought this pulse into the oscillator clock domain. Once hold is released, the block counts the ticks spent tracking. A start that arrives before the minimum track time has elapsed is dropped and reported on an error strobe. In continuous mode, the pulse that marks the last result bit leaving the serial port requests the next conversion. That request is held pending until the track time is met and is then launched. A disable input aborts any conversion in progress and returns the block to track.

The minimum track time is derived from the oscillator frequency and a track time in nanoseconds. With the defaults, a 2000 kHz oscillator and 3500 ns give 7 ticks. Each bit takes 4 ticks, so a conversion takes 32 ticks.

Top module: `sar_seq`

## Requirements
- R1: After reset `hold`, `result_valid`, `early_err` are 0 and `trial_code` is 0x00.
- R2: With `enable` high, in track and with the track time met, a start pulse sampled on a rising edge raises `hold` from that edge. `trial_code` then reads 0x80, which is the most significant bit set alone.
- R3: Each bit occupies 4 ticks. `cmp_ge` (1 means input at or above the trial level) is sampled only on the 4th tick of the bit. The bit is kept if `cmp_ge` is 1 and cleared if it is 0, and the next lower bit is set. After 3 ticks `trial_code` still reads 0x80. After the 4th tick it reads 0xC0 for an input of 200 and 0x40 for an input of 100.
- R4: On the 32nd rising edge after the launching edge, `hold` falls and `result_valid` rises. `result` then holds the straight-binary code, equal to the input for inputs 0 to 255. Until that edge `hold` stays 1 and `result_valid` stays 0.
- R5: An input below 0 gives a result of 0x00, and an input above 255 gives 0xFF.
- R6: Tracking time is counted in edges since hold fell. A start sampled on the 8th edge after the edge that ended hold, or later, is accepted. A start sampled earlier is dropped, `hold` stays 0, and `early_err` is 1 for exactly one cycle.
- R7: A start pulse during a conversion is ignored. It raises no error and does not change the result or the 32-edge timing.
- R8: A `result_shifted` pulse clears `result_valid` on the next edge. In single mode (`cont_mode` = 0) it starts nothing.
- R9: In continuous mode, a `result_shifted` pulse while a result is valid requests the next conversion. If the track time is already met, the conversion launches on the edge that samples the pulse. Otherwise it launches on the first edge where the track time is met. Sampled 2 edges after the end of hold, this is the 8th edge.
- R10: With `enable` low, the edge that samples it drops `hold` and `result_valid` and clears `trial_code` to 0x00. Start pulses are ignored while `enable` is low, with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable; low aborts and forces track |
| cont_mode | input | 1 | 1 = continuous restart, 0 = single conversion |
| start_pulse | input | 1 | One-cycle conversion request from serial side |
| result_shifted | input | 1 | One-cycle pulse: last result bit has left the serial port |
| cmp_ge | input | 1 | Comparator: input at or above trial level |
| hold | output | 1 | 1 = hold, 0 = track |
| trial_code | output | 8 | Trial code to the comparator DAC |
| result | output | 8 | Last completed conversion code |
| result_valid | output | 1 | Result ready to be shifted out |
| early_err | output | 1 | Start dropped because tracking was too short |

## Verification
`hold` follows the launching edge by one register, so the bench reads it at the falling edge right after the start is sampled. The bench counts falling edges from that point and checks `result_valid` just before and just after the 32nd rising edge. The track-time boundary is probed from the falling edge that sees `result_valid` rise: a start sampled 7 edges later must raise `early_err` on the next half cycle, and one sampled 8 edges later must raise `hold`. The continuous-mode launch, the one-edge abort on disable, and the clearing of `result_valid` are each checked on both sides of the edge where they are due.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    SAR_TRACK = 1'b0,
    SAR_CONV  = 1'b1
  } sar_state_e;
endpackage

// File: rtl/sar_track_timer.sv
// Counts ticks spent tracking, saturating at the minimum track time.
module sar_track_timer #(
  parameter int TRACK_TICKS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tracking,
  output logic track_ok
);
  localparam int CW = $clog2(TRACK_TICKS + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!tracking) begin
      cnt_d = '0;
    end else if (cnt_q != CW'(TRACK_TICKS)) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign track_ok = (cnt_q == CW'(TRACK_TICKS));
endmodule

// File: rtl/sar_step_timer.sv
// Paces the bit trials: TRIAL_TICKS ticks per bit, MSB index first.
module sar_step_timer #(
  parameter int WIDTH       = 8,
  parameter int TRIAL_TICKS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     run,
  output logic                     step,
  output logic                     last,
  output logic [$clog2(WIDTH)-1:0] bit_idx
);
  localparam int IW = $clog2(WIDTH);
  localparam int TW = (TRIAL_TICKS > 1) ? $clog2(TRIAL_TICKS) : 1;
  localparam logic [TW-1:0] LAST_TICK = TW'(TRIAL_TICKS - 1);

  logic [TW-1:0] tick_q, tick_d;
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    tick_d = tick_q;
    idx_d  = idx_q;
    if (load) begin
      tick_d = '0;
      idx_d  = IW'(WIDTH - 1);
    end else if (run) begin
      if (tick_q == LAST_TICK) begin
        tick_d = '0;
        if (idx_q != '0) idx_d = idx_q - IW'(1);
      end else begin
        tick_d = tick_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      idx_q  <= '0;
    end else begin
      tick_q <= tick_d;
      idx_q  <= idx_d;
    end
  end

  assign step    = run && !load && (tick_q == LAST_TICK);
  assign last    = step && (idx_q == '0);
  assign bit_idx = idx_q;
endmodule

// File: rtl/sar_trial_reg.sv
// Trial code register: set a bit, keep it on a comparator "at or above".
module sar_trial_reg #(
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     load,
  input  logic                     step,
  input  logic                     cmp_ge,
  input  logic [$clog2(WIDTH)-1:0] bit_idx,
  output logic [WIDTH-1:0]         code
);
  localparam int IW = $clog2(WIDTH);

  logic [WIDTH-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (clear) begin
      code_d = '0;
    end else if (load) begin
      code_d = '0;
      code_d[WIDTH-1] = 1'b1;
    end else if (step) begin
      code_d[bit_idx] = cmp_ge;
      if (bit_idx != '0) code_d[bit_idx - IW'(1)] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign code = code_q;
endmodule

// File: rtl/sar_seq.sv
// Conversion sequencer top: track/hold control, launch, restart, abort.
module sar_seq #(
  parameter int WIDTH       = 8,
  parameter int TRIAL_TICKS = 4,
  parameter int CLK_KHZ     = 2000,
  parameter int TRACK_NS    = 3500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cont_mode,
  input  logic             start_pulse,
  input  logic             result_shifted,
  input  logic             cmp_ge,
  output logic             hold,
  output logic [WIDTH-1:0] trial_code,
  output logic [WIDTH-1:0] result,
  output logic             result_valid,
  output logic             early_err
);
  import sar_pkg::*;

  localparam int TRACK_RAW   = (CLK_KHZ * TRACK_NS + 999_999) / 1_000_000;
  localparam int TRACK_TICKS = (TRACK_RAW < 1) ? 1 : TRACK_RAW;
  localparam int IW          = $clog2(WIDTH);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  sar_state_e       state_q, state_d;
  logic             pend_q, pend_d;
  logic             valid_q, valid_d;
  logic             err_q, err_d;
  logic [WIDTH-1:0] res_q, res_d;

  logic          conv, track_ok, launch, cont_req;
  logic          step, last;
  logic [IW-1:0] bit_idx;

  assign conv = (state_q == SAR_CONV);

  sar_track_timer #(.TRACK_TICKS(TRACK_TICKS)) u_track (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tracking (!conv),
    .track_ok (track_ok)
  );

  sar_step_timer #(.WIDTH(WIDTH), .TRIAL_TICKS(TRIAL_TICKS)) u_step (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (launch),
    .run     (conv),
    .step    (step),
    .last    (last),
    .bit_idx (bit_idx)
  );

  sar_trial_reg #(.WIDTH(WIDTH)) u_trial (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clear   (!enable),
    .load    (launch),
    .step    (step && enable),
    .cmp_ge  (cmp_ge),
    .bit_idx (bit_idx),
    .code    (trial_code)
  );

  always_comb begin
    cont_req = cont_mode && result_shifted && valid_q && !conv;
    launch   = enable && !conv && track_ok && (start_pulse || pend_q || cont_req);
    err_d    = enable && !conv && !track_ok && start_pulse;

    state_d = state_q;
    pend_d  = pend_q;
    valid_d = valid_q;
    res_d   = res_q;

    if (!enable) begin
      state_d = SAR_TRACK;
      pend_d  = 1'b0;
      valid_d = 1'b0;
    end else if (launch) begin
      state_d = SAR_CONV;
      pend_d  = 1'b0;
      valid_d = 1'b0;
    end else begin
      if (cont_req) pend_d = 1'b1;
      if (result_shifted) valid_d = 1'b0;
      if (conv && last) begin
        state_d = SAR_TRACK;
        valid_d = 1'b1;
        res_d   = {trial_code[WIDTH-1:1], cmp_ge};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= SAR_TRACK;
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      valid_q <= valid_d;
      err_q   <= err_d;
      res_q   <= res_d;
    end
  end

  assign hold         = conv;
  assign result       = res_q;
  assign result_valid = valid_q;
  assign early_err    = err_q;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int CONV_CYCLES = 32,
  parameter int TRACK_TICKS = 7
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic start_pulse,
  input logic hold,
  input logic result_valid,
  input logic early_err
);
  int hold_run;
  int track_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_run  <= 0;
      track_run <= 0;
    end else begin
      hold_run  <= hold ? hold_run + 1 : 0;
      track_run <= hold ? 0 : ((track_run < TRACK_TICKS) ? track_run + 1 : track_run);
    end
  end

  AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(result_valid) |-> (hold_run == CONV_CYCLES)); // R4

  AST_TRACK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(result_valid) |-> !hold); // R4

  AST_TRACK_MINIMUM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> ($past(track_run) >= TRACK_TICKS)); // R6

  AST_EARLY_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    early_err |-> ($past(start_pulse) && !$past(hold) && !hold)); // R6

  AST_DISABLE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!hold && !result_valid)); // R10
endmodule

bind sar_seq sar_seq_chk #(
  .CONV_CYCLES (WIDTH * TRIAL_TICKS),
  .TRACK_TICKS (TRACK_TICKS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .enable       (enable),
  .start_pulse  (start_pulse),
  .hold         (hold),
  .result_valid (result_valid),
  .early_err    (early_err)
);

// File: tb/tb_sar_seq.sv
module tb_sar_seq;
  logic       clk;
  logic       rst_n;
  logic       enable;
  logic       cont_mode;
  logic       start_pulse;
  logic       result_shifted;
  logic       cmp_ge;
  logic       hold;
  logic [7:0] trial_code;
  logic [7:0] result;
  logic       result_valid;
  logic       early_err;

  int vin;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  sar_seq dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable         (enable),
    .cont_mode      (cont_mode),
    .start_pulse    (start_pulse),
    .result_shifted (result_shifted),
    .cmp_ge         (cmp_ge),
    .hold           (hold),
    .trial_code     (trial_code),
    .result         (result),
    .result_valid   (result_valid),
    .early_err      (early_err)
  );

  // comparator model: input at or above the trial level
  assign cmp_ge = (vin >= int'(trial_code));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one start pulse; returns at the falling edge after it was sampled
  task automatic pulse_start();
    start_pulse = 1'b1;
    @(negedge clk);
    start_pulse = 1'b0;
  endtask

  // at = edges since the launching edge; ends at the falling edge after completion
  task automatic finish_conv(input int at, input int exp, input string req);
    idle(31 - at);
    check_eq(req, "valid before edge 32", int'(result_valid), 0);
    check_eq(req, "hold before edge 32", int'(hold), 1);
    @(negedge clk);
    check_eq(req, "valid at edge 32", int'(result_valid), 1);
    check_eq(req, "hold at edge 32", int'(hold), 0);
    check_eq(req, "result", int'(result), exp);
  endtask

  task automatic t_reset();
    idle(3);
    check_eq("R1", "hold", int'(hold), 0);
    check_eq("R1", "result_valid", int'(result_valid), 0);
    check_eq("R1", "early_err", int'(early_err), 0);
    check_eq("R1", "trial_code", int'(trial_code), 0);
  endtask

  task automatic t_single(input int v, input int exp, input string req);
    vin = v;
    idle(10);
    pulse_start();
    check_eq("R2", "hold after start", int'(hold), 1);
    check_eq("R2", "first trial code", int'(trial_code), 8'h80);
    finish_conv(0, exp, req);
  endtask

  task automatic t_bit_timing(input int v, input int exp4);
    vin = v;
    idle(10);
    pulse_start();
    idle(3);
    check_eq("R3", "code after 3 ticks", int'(trial_code), 8'h80);
    @(negedge clk);
    check_eq("R3", "code after 4 ticks", int'(trial_code), exp4);
    finish_conv(4, v, "R3");
  endtask

  task automatic t_early();
    t_single(60, 60, "R4");
    idle(6);
    pulse_start();
    check_eq("R6", "early_err after 7-edge start", int'(early_err), 1);
    check_eq("R6", "hold stays low", int'(hold), 0);
    @(negedge clk);
    check_eq("R6", "early_err one cycle", int'(early_err), 0);
    check_eq("R6", "still tracking", int'(hold), 0);
  endtask

  task automatic t_track_boundary();
    t_single(33, 33, "R4");
    vin = 90;
    idle(7);
    pulse_start();
    check_eq("R6", "start at 8th edge accepted", int'(hold), 1);
    check_eq("R6", "no error at 8th edge", int'(early_err), 0);
    finish_conv(0, 90, "R6");
  endtask

  task automatic t_busy();
    vin = 140;
    idle(10);
    pulse_start();
    idle(5);
    pulse_start();
    check_eq("R7", "no error while busy", int'(early_err), 0);
    check_eq("R7", "still holding", int'(hold), 1);
    finish_conv(6, 140, "R7");
  endtask

  task automatic t_shift_clear();
    result_shifted = 1'b1;
    @(negedge clk);
    result_shifted = 1'b0;
    check_eq("R8", "valid cleared", int'(result_valid), 0);
    idle(12);
    check_eq("R8", "no restart in single mode", int'(hold), 0);
    check_eq("R8", "valid stays low", int'(result_valid), 0);
  endtask

  task automatic t_cont();
    cont_mode = 1'b1;
    t_single(77, 77, "R4");
    idle(1);
    result_shifted = 1'b1;
    @(negedge clk);
    result_shifted = 1'b0;
    vin = 150;
    check_eq("R9", "valid cleared by shift", int'(result_valid), 0);
    check_eq("R9", "restart pending", int'(hold), 0);
    idle(5);
    check_eq("R9", "no launch before track time", int'(hold), 0);
    @(negedge clk);
    check_eq("R9", "launch at 8th edge", int'(hold), 1);
    finish_conv(0, 150, "R9");
    vin = 21;
    idle(9);
    result_shifted = 1'b1;
    @(negedge clk);
    result_shifted = 1'b0;
    check_eq("R9", "late request launches at once", int'(hold), 1);
    finish_conv(0, 21, "R9");
    cont_mode = 1'b0;
    t_shift_clear();
  endtask

  task automatic t_disable();
    vin = 180;
    idle(10);
    pulse_start();
    idle(10);
    enable = 1'b0;
    @(negedge clk);
    check_eq("R10", "hold dropped", int'(hold), 0);
    check_eq("R10", "valid low", int'(result_valid), 0);
    check_eq("R10", "trial code cleared", int'(trial_code), 0);
    idle(10);
    pulse_start();
    check_eq("R10", "start ignored while disabled", int'(hold), 0);
    check_eq("R10", "no error while disabled", int'(early_err), 0);
    enable = 1'b1;
    idle(3);
    check_eq("R10", "no result after abort", int'(result_valid), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    enable = 1'b1;
    cont_mode = 1'b0;
    start_pulse = 1'b0;
    result_shifted = 1'b0;
    vin = 0;
    idle(4);
    rst_n = 1'b1;
    t_reset();
    t_single(100, 100, "R4");
    t_single(0, 0, "R4");
    t_single(255, 255, "R4");
    t_single(-7, 0, "R5");
    t_single(400, 255, "R5");
    t_bit_timing(200, 8'hC0);
    t_bit_timing(100, 8'h40);
    t_early();
    t_track_boundary();
    t_busy();
    t_shift_clear();
    t_cont();
    t_disable();
    t_single(201, 201, "R4");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule